// File: doc/BRIEF.md
# Integer-Plus-Float Sequential Adder

This unit adds a 32-bit two's-complement integer to a single-precision floating-point value and returns the single-precision sum. A one-cycle start pulse launches the operation. The unit samples both operands on that same edge. A controller then steps a small datapath through a fixed sequence of simple register transfers: classify, convert the integer, order the operands, align, add or subtract, normalise, and round. A one-cycle done pulse marks the result.

The integer is converted by taking its magnitude and locating the leading one. That position sets the exponent, and a left shift normalises the significand. The smaller operand is shifted right, and every bit shifted out is folded into a sticky bit, so the final round-to-nearest-even decision sees all the discarded information. A float operand that is infinite skips the arithmetic. A float operand with a zero exponent field is treated as zero. NaN operands are not supported, no denormal results are produced, and no exception flags are raised.

Top module: `mixadd_unit`

## Requirements
- R1: An operation starts when start_i is high while the unit is idle. int_i and flt_i are sampled on that same clock edge, and later changes to them do not affect the result.
- R2: done_o is high for exactly one cycle. sum_o carries the result in that cycle and holds the same value in the following cycle.
- R3: A start_i pulse that arrives while an operation is in progress is ignored. It neither changes the result nor produces an extra done_o pulse.
- R4: If the float exponent field is all ones, the result is an infinity with the float operand's sign: 0x7F800000 or 0xFF800000.
- R5: A float operand whose exponent field is 0 counts as zero, whatever its sign and fraction. The result is then the integer converted to single precision. An integer of 0 in that case gives +0 (0x00000000).
- R6: An integer operand of 0 with a finite, nonzero float operand returns the float operand unchanged.
- R7: In all other cases the result is the exact sum rounded to nearest. An exact cancellation gives +0, and a finite input never produces an all-ones exponent.
- R8: Rounding considers every discarded bit. A discarded part above one half ulp rounds the magnitude up, and one below half rounds it down, even when the first discarded bit alone would suggest otherwise.
- R9: A discarded part of exactly one half ulp rounds to the value whose 24-bit significand is even (its least significant bit is 0).
- R10: A round-up that carries out of the 24-bit significand gives significand 1.0 and raises the exponent by one. For example, 0x7FFFFFFF converts to 0x4F000000.
- R11: While reset is held, and at the moment it is released, done_o is 0 and sum_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle launch pulse |
| int_i | input | 32 | Signed integer operand |
| flt_i | input | 32 | Single-precision operand (sign bit 31, exponent bits 30:23, fraction bits 22:0) |
| done_o | output | 1 | One-cycle result strobe |
| sum_o | output | 32 | Single-precision sum |

## Verification
The addition path is driven with several operand mixes, and each mix separates a different part of the datapath:
- Same-sign and opposite-sign pairs with small exponent gaps check the order and subtract logic, including a result whose sign comes from the float.
- An exact cancellation checks that the zero-result path gives +0.
- A huge float against a small negative integer checks the far-shift sticky path.
- Integers just above 2^24, combined with ±0.25, tell a rounder that looks only at the guard bit apart from one that uses all discarded bits.
- Ties just above 2^24 at odd and even significands check the tie-break direction.
- Zero and infinite operands, a float with a zero exponent field but a nonzero fraction, and INT_MIN and INT_MAX check the short paths and the rounding carry.

// File: rtl/mixadd_pkg.sv
`timescale 1ns/1ps
package mixadd_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_CLASS,
    S_CONV,
    S_ORDER,
    S_ALIGN,
    S_ADD,
    S_NORM,
    S_ROUND,
    S_DONE,
    S_HOLD
  } mxa_state_e;
endpackage

// File: rtl/mixadd_lzc.sv
`timescale 1ns/1ps
// leading-zero count; returns W when the input is all zeros
module mixadd_lzc #(
  parameter int W  = 32,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  in_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (in_i[i]) cnt_o = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/mixadd_rshift.sv
`timescale 1ns/1ps
// right shift, every lost bit ORed into bit 0
module mixadd_rshift #(
  parameter int W    = 40,
  parameter int SH_W = 10
) (
  input  logic [W-1:0]    in_i,
  input  logic [SH_W-1:0] sh_i,
  output logic [W-1:0]    out_o
);
  logic [W-1:0] lost_mask;
  logic         sticky;

  always_comb begin
    lost_mask = ~({W{1'b1}} << sh_i);
    sticky    = |(in_i & lost_mask);
    out_o     = (in_i >> sh_i) | {{(W-1){1'b0}}, sticky};
  end
endmodule

// File: rtl/mixadd_round.sv
`timescale 1ns/1ps
// round-to-nearest-even of a normalised wide significand, then pack
module mixadd_round #(
  parameter int NW    = 41,
  parameter int EXP_W = 8,
  parameter int FRC_W = 23,
  parameter int E_W   = EXP_W + 2
) (
  input  logic                     sgn_i,
  input  logic [E_W-1:0]           exp_i,
  input  logic [NW-1:0]            sig_i,
  output logic [EXP_W+FRC_W:0]     word_o
);
  localparam int MAN_W = FRC_W + 1;
  localparam int DW    = NW - MAN_W;
  localparam int EMAX  = (1 << EXP_W) - 1;

  logic [MAN_W-1:0] kept;
  logic [DW-1:0]    disc;
  logic [DW-1:0]    half;
  logic             up;
  logic [MAN_W:0]   rnd;
  logic [E_W-1:0]   e_r;
  logic [FRC_W-1:0] frac;

  always_comb begin
    kept = sig_i[NW-1 -: MAN_W];
    disc = sig_i[DW-1:0];
    half = {1'b1, {(DW-1){1'b0}}};
    up   = (disc > half) || ((disc == half) && kept[0]);
    rnd  = {1'b0, kept} + (MAN_W+1)'(up);
    e_r  = rnd[MAN_W] ? exp_i + E_W'(1) : exp_i;
    frac = rnd[MAN_W] ? '0 : rnd[FRC_W-1:0];
    if (e_r >= E_W'(EMAX))
      word_o = {sgn_i, {EXP_W{1'b1}}, {FRC_W{1'b0}}};
    else
      word_o = {sgn_i, e_r[EXP_W-1:0], frac};
  end
endmodule

// File: rtl/mixadd_unit.sv
`timescale 1ns/1ps
module mixadd_unit #(
  parameter int INT_W = 32,
  parameter int EXP_W = 8,
  parameter int FRC_W = 23,
  parameter int GRD_W = 7
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [INT_W-1:0]       int_i,
  input  logic [EXP_W+FRC_W:0]   flt_i,
  output logic                   done_o,
  output logic [EXP_W+FRC_W:0]   sum_o
);
  import mixadd_pkg::*;

  localparam int FLT_W = 1 + EXP_W + FRC_W;
  localparam int MAN_W = FRC_W + 1;
  localparam int SIG_W = INT_W;
  localparam int WK_W  = SIG_W + GRD_W + 1;
  localparam int NW    = WK_W + 1;
  localparam int E_W   = EXP_W + 2;
  localparam int ACW   = $clog2(INT_W + 1);
  localparam int NCW   = $clog2(NW + 1);
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;

  mxa_state_e state_q;
  logic       busy;

  logic [INT_W-1:0] int_q, mag_q;
  logic [FLT_W-1:0] flt_q, res_q;
  logic             sgn_a_q, sgn_big_q, sub_q;
  logic [E_W-1:0]   e_a_q, e_big_q, dif_q, exp_q;
  logic [SIG_W-1:0] sig_a_q;
  logic [WK_W-1:0]  big_q, sml_q;
  logic [NW-1:0]    sum_q;

  // float operand fields
  logic             f_sgn, f_inf, f_zero;
  logic [EXP_W-1:0] f_exp;
  logic [E_W-1:0]   e_b;
  logic [SIG_W-1:0] sig_b;

  assign f_sgn  = flt_q[FLT_W-1];
  assign f_exp  = flt_q[FLT_W-2 -: EXP_W];
  assign f_inf  = &f_exp;
  assign f_zero = ~|f_exp;
  assign e_b    = f_zero ? '0 : E_W'(f_exp);
  assign sig_b  = f_zero ? '0 : {1'b1, flt_q[FRC_W-1:0], {(SIG_W-MAN_W){1'b0}}};

  assign busy   = (state_q != S_IDLE);
  assign done_o = (state_q == S_DONE);
  assign sum_o  = res_q;

  logic [ACW-1:0] lz_a;
  logic [NCW-1:0] lz_n;
  logic [WK_W-1:0] sml_sh;
  logic [FLT_W-1:0] rnd_word;

  mixadd_lzc #(.W(INT_W), .CW(ACW)) u_lz_int (.in_i(mag_q), .cnt_o(lz_a));
  mixadd_lzc #(.W(NW), .CW(NCW)) u_lz_sum (.in_i(sum_q), .cnt_o(lz_n));
  mixadd_rshift #(.W(WK_W), .SH_W(E_W)) u_align (.in_i(sml_q), .sh_i(dif_q), .out_o(sml_sh));
  mixadd_round #(.NW(NW), .EXP_W(EXP_W), .FRC_W(FRC_W), .E_W(E_W)) u_round (
    .sgn_i(sgn_big_q), .exp_i(exp_q), .sig_i(sum_q), .word_o(rnd_word)
  );

  // operand ordering by magnitude
  logic           a_ge;
  logic [E_W-1:0] e_hi, e_lo;
  logic [SIG_W-1:0] s_hi, s_lo;
  always_comb begin
    a_ge = (e_a_q > e_b) || ((e_a_q == e_b) && (sig_a_q >= sig_b));
    e_hi = a_ge ? e_a_q : e_b;
    e_lo = a_ge ? e_b : e_a_q;
    s_hi = a_ge ? sig_a_q : sig_b;
    s_lo = a_ge ? sig_b : sig_a_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      int_q     <= '0;
      flt_q     <= '0;
      mag_q     <= '0;
      sgn_a_q   <= 1'b0;
      e_a_q     <= '0;
      sig_a_q   <= '0;
      e_big_q   <= '0;
      sgn_big_q <= 1'b0;
      sub_q     <= 1'b0;
      dif_q     <= '0;
      big_q     <= '0;
      sml_q     <= '0;
      sum_q     <= '0;
      exp_q     <= '0;
      res_q     <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (!busy && start_i) begin
          int_q   <= int_i;
          flt_q   <= flt_i;
          state_q <= S_CLASS;
        end
        S_CLASS: begin
          if (f_inf) begin
            res_q   <= {f_sgn, {EXP_W{1'b1}}, {FRC_W{1'b0}}};
            state_q <= S_DONE;
          end else begin
            sgn_a_q <= int_q[INT_W-1];
            mag_q   <= int_q[INT_W-1] ? (~int_q + INT_W'(1)) : int_q;
            state_q <= S_CONV;
          end
        end
        S_CONV: begin
          sig_a_q <= mag_q << lz_a;
          e_a_q   <= (mag_q == '0) ? '0 : E_W'(BIAS + INT_W - 1) - E_W'(lz_a);
          state_q <= S_ORDER;
        end
        S_ORDER: begin
          big_q     <= {s_hi, {(GRD_W+1){1'b0}}};
          sml_q     <= {s_lo, {(GRD_W+1){1'b0}}};
          dif_q     <= e_hi - e_lo;
          e_big_q   <= e_hi;
          sgn_big_q <= a_ge ? sgn_a_q : f_sgn;
          sub_q     <= sgn_a_q ^ f_sgn;
          state_q   <= S_ALIGN;
        end
        S_ALIGN: begin
          sml_q   <= sml_sh;
          state_q <= S_ADD;
        end
        S_ADD: begin
          sum_q   <= sub_q ? ({1'b0, big_q} - {1'b0, sml_q})
                           : ({1'b0, big_q} + {1'b0, sml_q});
          state_q <= S_NORM;
        end
        S_NORM: begin
          if (sum_q == '0) begin
            res_q   <= '0;
            state_q <= S_DONE;
          end else begin
            sum_q   <= sum_q << lz_n;
            exp_q   <= e_big_q + E_W'(1) - E_W'(lz_n);
            state_q <= S_ROUND;
          end
        end
        S_ROUND: begin
          res_q   <= rnd_word;
          state_q <= S_DONE;
        end
        S_DONE:  state_q <= S_HOLD;
        S_HOLD:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mixadd_chk.sv
`timescale 1ns/1ps
module mixadd_chk #(
  parameter int INT_W = 32,
  parameter int EXP_W = 8,
  parameter int FRC_W = 23
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 done_i,
  input logic                 busy_i,
  input logic [EXP_W+FRC_W:0] sum_i,
  input logic [INT_W-1:0]     int_op_i,
  input logic [EXP_W+FRC_W:0] flt_op_i
);
  localparam int FLT_W = 1 + EXP_W + FRC_W;

  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  // R2
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> $stable(sum_i));

  // R3
  busy_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> ($stable(int_op_i) && $stable(flt_op_i)));

  // R4
  inf_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && (&flt_op_i[FLT_W-2 -: EXP_W]))
      |-> (sum_i == {flt_op_i[FLT_W-1], {EXP_W{1'b1}}, {FRC_W{1'b0}}}));

  // R5
  zero_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && (flt_op_i[FLT_W-2 -: EXP_W] == '0) && (int_op_i == '0))
      |-> (sum_i == '0));

  // R7
  finite_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !(&flt_op_i[FLT_W-2 -: EXP_W]))
      |-> !(&sum_i[FLT_W-2 -: EXP_W]));
endmodule

bind mixadd_unit mixadd_chk #(.INT_W(INT_W), .EXP_W(EXP_W), .FRC_W(FRC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .done_i(done_o), .busy_i(busy),
  .sum_i(sum_o), .int_op_i(int_q), .flt_op_i(flt_q)
);

// File: tb/sim_mixadd_unit.sv
`timescale 1ns/1ps
module sim_mixadd_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] ia = '0;
  logic [31:0] fb = '0;
  logic        done;
  logic [31:0] sum;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  mixadd_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .int_i(ia), .flt_i(fb), .done_o(done), .sum_o(sum)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // pulse start with operands, hold them two cycles, then scramble
  task automatic launch(input logic [31:0] a, input logic [31:0] f);
    @(negedge clk);
    start = 1'b1; ia = a; fb = f;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    ia = 32'hDEAD_BEEF; fb = 32'h4123_4567;
  endtask

  task automatic wait_done(output logic [31:0] r, output bit ok);
    ok = 1'b0;
    r  = '0;
    for (int i = 0; i < 40; i++) begin
      if (done) begin
        ok = 1'b1;
        r  = sum;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic op(input logic [31:0] a, input logic [31:0] f,
                    input logic [31:0] exp, input string req);
    logic [31:0] r;
    bit ok;
    launch(a, f);
    wait_done(r, ok);
    if (!ok) begin
      check({req, " done timeout"}, 32'h0, 32'h1);
      return;
    end
    check(req, r, exp);
    @(negedge clk);
    check("R2 done one cycle", {31'h0, done}, 32'h0);
    check("R2 sum held", sum, exp);
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R11 done in reset", {31'h0, done}, 32'h0);
    check("R11 sum in reset", sum, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 done after reset", {31'h0, done}, 32'h0);
    check("R11 sum after reset", sum, 32'h0);
  endtask

  task automatic t_float_zero;
    op(32'd5, 32'h0000_0000, 32'h40A0_0000, "R5 5 + +0");
    op(-32'sd7, 32'h8000_0000, 32'hC0E0_0000, "R5 -7 + -0");
    op(32'd5, 32'h0000_0001, 32'h40A0_0000, "R5 zero-exponent fraction");
    op(32'd0, 32'h8000_0000, 32'h0000_0000, "R5 0 + -0");
    op(32'd0, 32'h0000_0000, 32'h0000_0000, "R5 0 + +0");
  endtask

  task automatic t_int_zero;
    op(32'd0, 32'h3FC0_0000, 32'h3FC0_0000, "R6 0 + 1.5");
    op(32'd0, 32'hBFC0_0000, 32'hBFC0_0000, "R6 0 + -1.5");
  endtask

  task automatic t_infinity;
    op(32'd123, 32'h7F80_0000, 32'h7F80_0000, "R4 123 + inf");
    op(-32'sd5, 32'hFF80_0000, 32'hFF80_0000, "R4 -5 + -inf");
  endtask

  task automatic t_basic;
    op(32'd1, 32'h3F80_0000, 32'h4000_0000, "R7 1 + 1.0 (R1 scrambled inputs)");
    op(32'd3, 32'h3F00_0000, 32'h4060_0000, "R7 3 + 0.5");
    op(32'd2, 32'hBF00_0000, 32'h3FC0_0000, "R7 2 + -0.5");
    op(-32'sd1, 32'h3F80_0000, 32'h0000_0000, "R7 -1 + 1.0 cancel");
    op(32'd1, 32'hC040_0000, 32'hC000_0000, "R7 1 + -3.0");
    op(32'd1, 32'hBFC0_0000, 32'hBF00_0000, "R7 1 + -1.5");
  endtask

  task automatic t_sticky;
    op(32'd16777217, 32'h3E80_0000, 32'h4B80_0001, "R8 above half");
    op(32'd16777217, 32'hBE80_0000, 32'h4B80_0000, "R8 below half");
    op(-32'sd5, 32'h7F7F_FFFF, 32'h7F7F_FFFF, "R8 far shift sticky");
  endtask

  task automatic t_tie;
    op(32'd16777217, 32'h0000_0000, 32'h4B80_0000, "R9 tie stays even");
    op(32'd16777219, 32'h0000_0000, 32'h4B80_0002, "R9 tie rounds up to even");
    op(-32'sd16777217, 32'h0000_0000, 32'hCB80_0000, "R9 negative tie");
  endtask

  task automatic t_carry;
    op(32'h7FFF_FFFF, 32'h0000_0000, 32'h4F00_0000, "R10 round carry");
    op(32'h8000_0000, 32'h0000_0000, 32'hCF00_0000, "R10 most negative int");
  endtask

  task automatic t_busy;
    int pulses = 0;
    logic [31:0] r = '0;
    launch(32'd1, 32'h3F80_0000);
    @(negedge clk);
    start = 1'b1; ia = 32'd3; fb = 32'h3F00_0000;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 30; i++) begin
      if (done) begin
        pulses++;
        r = sum;
      end
      @(negedge clk);
    end
    check("R3 result of first op", r, 32'h4000_0000);
    check("R3 single done pulse", 32'(pulses), 32'd1);
  endtask

  initial begin
    t_reset();
    t_float_zero();
    t_int_zero();
    t_infinity();
    t_basic();
    t_sticky();
    t_tie();
    t_carry();
    t_busy();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #4ms;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule